// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block collects interrupt requests from six sources for a small 8-bit microcontroller core. There are four on-chip peripherals and two external pins. Each request is held in a flag bit. A flag is set whether or not its source is enabled. A per-source enable, a global enable and a two-level priority field decide which flag may interrupt the core. At an instruction boundary the controller picks the winning source and starts a forced subroutine call. That call takes six cycles, and during it the call target is driven as `8*n + 3` for source index `n`. The controller then announces entry into the service routine.

The controller records which priority levels are in service. A routine at a level can be preempted only by a request of a strictly higher level. A return-from-interrupt pulse from the core releases the highest level in service. Software reads and writes the flag, enable, priority and trigger-mode fields through a small synchronous register port with four byte-wide addresses.

Source indices are: 0 external pin 0, 1 radio FIFO error, 2 external pin 1, 3 serial port 0 receive, 4 converter done, 5 serial port 1 receive. Lower index means higher precedence within one priority level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x05 (both trigger-mode bits 1, all flags 0), addresses 1, 2 and 3 read 0x00, and `call_busy` and `vec_enter` are 0.
- R2: A one-cycle pulse on `per_req` sets the flag of its source whatever the enables hold. Bit 0 maps to source 1, bit 1 to source 3, bit 2 to source 4 and bit 3 to source 5.
- R3: Address 0 shows the flag of source 5 at bit 7, source 4 at bit 5, source 3 at bit 3 and source 1 at bit 1. It shows the mode of pin 1 at bit 2 and the mode of pin 0 at bit 0. Bits 6 and 4 read 0. Address 1 shows the flag of source 0 at bit 0 and of source 2 at bit 1.
- R4: A register write sets or clears flags at those positions. When a hardware request and a software clear of the same flag meet in one cycle, the flag ends set.
- R5: Address 2 holds the global enable at bit 7 and the enable of source n at bit n. A flag whose source enable or global enable is 0 is never taken, but it stays latched.
- R6: When a taken flag first becomes visible in cycle f, `call_busy` is high in cycles f+1 to f+6 with `call_vec` = 8n+3. `vec_enter` pulses in cycle f+7, which is seven cycles after detection.
- R7: The flag of a source is cleared by hardware in the cycle its call is taken.
- R8: Address 3 bit n set makes source n high priority. An eligible high source wins over any low one, and within one level the lowest index wins.
- R9: While a level is in service, only a request of a strictly higher level is taken. Equal or lower requests stay pending with their flags set.
- R10: A `reti` pulse releases the highest level in service, after which the best pending request is taken.
- R11: With mode bit 1 (edge), a pin flag is set by a high-to-low change between two consecutive cycles only. A pin held low does not set it again after it is cleared.
- R12: With mode bit 0 (level), a pin flag is set in every cycle the pin is low, so it cannot be cleared while the pin stays low.
- R13: A call is taken only in a cycle with `inst_bound` high and `call_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_req | input | 4 | Peripheral request pulses (sources 1, 3, 4, 5) |
| ext_n | input | 2 | Active-low external request pins (sources 0, 2) |
| inst_bound | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Core executed return-from-interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| call_busy | output | 1 | Forced call in progress |
| call_vec | output | VEC_W | Call target address |
| vec_enter | output | 1 | First cycle of the service routine |

## Verification
The assertions assume the core never pulses `reti` without a routine in service. They also assume `reti` never arrives in the same cycle as an acknowledge, and that the external pins are already synchronous to `clk`. The stimulus drives every input on the falling clock edge. It issues `reti` only after a call has finished and only as many times as calls were taken. It raises `inst_bound` only while `reti` is low.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NSRC  = 6;
  localparam int NEXT  = 2;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [NSRC-1:0] EXT_MASK = 6'b000101;

  // lowest index with its bit set; 0 when mask empty
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] m);
    lowest_set = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (m[i]) lowest_set = IDX_W'(i);
  endfunction

  function automatic int vec_of(input int n, input int stride, input int ofs);
    return n * stride + ofs;
  endfunction
endpackage

// File: rtl/nirq_flags.sv
module nirq_flags
  import nirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] per_set,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] edge_mode,
  input  logic            sw_we,
  input  logic [NSRC-1:0] sw_mask,
  input  logic [NSRC-1:0] sw_val,
  input  logic [NSRC-1:0] hw_clr,
  output logic [NSRC-1:0] flag_set,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] nxt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (EXT_MASK[i]) begin : g_ext
      localparam int E = i / 2;
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= ext_n[E];
      assign flag_set[i] = per_set[i] |
        (edge_mode[E] ? (pin_q & ~ext_n[E]) : ~ext_n[E]);
    end else begin : g_per
      assign flag_set[i] = per_set[i];
    end
  end

  always_comb begin
    nxt = flags;
    if (sw_we) nxt = (nxt & ~sw_mask) | (sw_val & sw_mask);
    nxt = nxt & ~hw_clr;
    nxt = nxt | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= nxt;

  AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R2
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb
  import nirq_pkg::*;
(
  input  logic [NSRC-1:0]  flags,
  input  logic [NSRC-1:0]  en,
  input  logic             gie,
  input  logic [NSRC-1:0]  prio,
  input  logic [1:0]       insvc,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx,
  output logic             req_lvl
);
  logic [NSRC-1:0] elig, hi, lo;

  assign elig = flags & en & {NSRC{gie}};
  assign hi   = elig & prio;
  assign lo   = elig & ~prio;

  always_comb begin
    req_valid = 1'b0;
    req_idx   = '0;
    req_lvl   = 1'b0;
    if (hi != '0 && !insvc[1]) begin
      req_valid = 1'b1;
      req_idx   = lowest_set(hi);
      req_lvl   = 1'b1;
    end else if (hi == '0 && lo != '0 && insvc == 2'b00) begin
      req_valid = 1'b1;
      req_idx   = lowest_set(lo);
    end
  end
endmodule

// File: rtl/nirq_nest.sv
module nirq_nest (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_i,
  input  logic       ack_lvl_i,
  input  logic       reti_i,
  output logic [1:0] insvc_o
);
  logic [1:0] nxt;

  always_comb begin
    nxt = insvc_o;
    if (reti_i) begin
      if (nxt[1]) nxt[1] = 1'b0;
      else        nxt[0] = 1'b0;
    end
    if (ack_i) nxt[ack_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) insvc_o <= 2'b00;
    else        insvc_o <= nxt;

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> (!insvc_o[1] && (ack_lvl_i || !insvc_o[0]))); // R9
  AST_RETI_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && insvc_o[1]) |=> (!insvc_o[1] && insvc_o[0] == $past(insvc_o[0]))); // R10
endmodule

// File: rtl/nirq_call_seq.sv
module nirq_call_seq
  import nirq_pkg::*;
#(
  parameter int CALL_CYC   = 6,
  parameter int VEC_W      = 16,
  parameter int VEC_STRIDE = 8,
  parameter int VEC_OFS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             busy_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             enter_o
);
  localparam int CNT_W = $clog2(CALL_CYC + 1);
  logic [CNT_W-1:0] cnt;

  assign busy_o = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      vec_o   <= '0;
      enter_o <= 1'b0;
    end else begin
      enter_o <= (cnt == CNT_W'(1));
      if (ack_i) begin
        cnt   <= CNT_W'(CALL_CYC);
        vec_o <= VEC_W'(vec_of(int'(idx_i), VEC_STRIDE, VEC_OFS));
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

  AST_CALL_THEN_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> enter_o); // R6
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(vec_o)); // R6
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int CALL_CYC   = 6,
  parameter int VEC_W      = 16,
  parameter int VEC_STRIDE = 8,
  parameter int VEC_OFS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       per_req,
  input  logic [1:0]       ext_n,
  input  logic             inst_bound,
  input  logic             reti,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             call_busy,
  output logic [VEC_W-1:0] call_vec,
  output logic             vec_enter
);
  localparam logic [1:0] A_FLAG = 2'd0, A_PIN = 2'd1, A_EN = 2'd2, A_PRIO = 2'd3;

  logic [NSRC-1:0] en_q, prio_q, flags, flag_set, per_set;
  logic [NSRC-1:0] sw_mask, sw_val, hw_clr;
  logic [1:0]      mode_q, insvc;
  logic            gie_q, sw_we;
  logic            req_valid, req_lvl, ack;
  logic [IDX_W-1:0] req_idx;

  assign per_set = {per_req[3], per_req[2], per_req[1], 1'b0, per_req[0], 1'b0};

  always_comb begin
    sw_we   = 1'b0;
    sw_mask = '0;
    sw_val  = '0;
    if (reg_wr && reg_addr == A_FLAG) begin
      sw_we   = 1'b1;
      sw_mask = 6'b111010;
      sw_val  = {reg_wdata[7], reg_wdata[5], reg_wdata[3], 1'b0, reg_wdata[1], 1'b0};
    end else if (reg_wr && reg_addr == A_PIN) begin
      sw_we   = 1'b1;
      sw_mask = 6'b000101;
      sw_val  = {3'b000, reg_wdata[1], 1'b0, reg_wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
      mode_q <= 2'b11;
    end else if (reg_wr) begin
      case (reg_addr)
        A_FLAG: mode_q <= {reg_wdata[2], reg_wdata[0]};
        A_EN: begin
          gie_q <= reg_wdata[7];
          en_q  <= reg_wdata[NSRC-1:0];
        end
        A_PRIO: prio_q <= reg_wdata[NSRC-1:0];
        default: ;
      endcase
    end

  always_comb
    case (reg_addr)
      A_FLAG: reg_rdata = {flags[5], 1'b0, flags[4], 1'b0, flags[3], mode_q[1], flags[1], mode_q[0]};
      A_PIN:  reg_rdata = {6'b0, flags[2], flags[0]};
      A_EN:   reg_rdata = {gie_q, 1'b0, en_q};
      default: reg_rdata = {2'b0, prio_q};
    endcase

  assign ack = inst_bound && !call_busy && req_valid;

  always_comb begin
    hw_clr = '0;
    if (ack) hw_clr[req_idx] = 1'b1;
  end

  nirq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_set(per_set), .ext_n(ext_n),
    .edge_mode(mode_q), .sw_we(sw_we), .sw_mask(sw_mask), .sw_val(sw_val),
    .hw_clr(hw_clr), .flag_set(flag_set), .flags(flags)
  );

  nirq_arb u_arb (
    .flags(flags), .en(en_q), .gie(gie_q), .prio(prio_q), .insvc(insvc),
    .req_valid(req_valid), .req_idx(req_idx), .req_lvl(req_lvl)
  );

  nirq_nest u_nest (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .ack_lvl_i(req_lvl),
    .reti_i(reti), .insvc_o(insvc)
  );

  nirq_call_seq #(
    .CALL_CYC(CALL_CYC), .VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE), .VEC_OFS(VEC_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .idx_i(req_idx),
    .busy_o(call_busy), .vec_o(call_vec), .enter_o(vec_enter)
  );

  AST_ACK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (gie_q && (flags & en_q) != '0)); // R5
  AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !flag_set[req_idx]) |=> !flags[$past(req_idx)]); // R7
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_busy) |-> $past(inst_bound)); // R13
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] per_req = '0;
  logic [1:0] ext_n = 2'b11;
  logic inst_bound = 1'b0, reti = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic call_busy, vec_enter;
  logic [15:0] call_vec;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .ext_n(ext_n),
    .inst_bound(inst_bound), .reti(reti), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .call_busy(call_busy),
    .call_vec(call_vec), .vec_enter(vec_enter)
  );

  function automatic int vec_for(input int src);
    return (src << 3) + 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  task automatic pulse(input int k);
    @(negedge clk); per_req[k] = 1'b1;
    @(negedge clk); per_req = '0;
  endtask

  task automatic give_reti;
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic expect_call(input string tag, input int vec);
    int seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (call_busy) seen = 1;
    end
    check({tag, " call taken"}, seen, 1);
    if (seen) check({tag, " vector"}, int'(call_vec), vec);
    for (int i = 0; i < 10 && call_busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string tag, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (call_busy) hits++;
    end
    check({tag, " no call"}, hits, 0);
  endtask

  task automatic t_reset;
    int d;
    rd(2'd0, d); check("R1 flag reg", d, 8'h05);
    rd(2'd1, d); check("R1 pin reg", d, 0);
    rd(2'd2, d); check("R1 enable reg", d, 0);
    rd(2'd3, d); check("R1 prio reg", d, 0);
    check("R1 busy", int'(call_busy), 0);
    check("R1 enter", int'(vec_enter), 0);
  endtask

  task automatic t_latch_layout;
    int d;
    for (int k = 0; k < 4; k++) pulse(k);
    @(negedge clk);
    rd(2'd0, d); check("R2 R3 flags latched while disabled", d, 8'hAF);
    check("R3 unused bits 6,4 zero", d & 8'h50, 0);
    wr(2'd0, 8'h05);
    rd(2'd0, d); check("R4 software clear", d, 8'h05);
    wr(2'd0, 8'h0D);
    rd(2'd0, d); check("R4 software set source 3", d, 8'h0D);
    wr(2'd1, 8'h03);
    rd(2'd1, d); check("R3 R4 pin flags at bits 1:0", d, 3);
    wr(2'd1, 8'h00);
    // clear and request on the same cycle: request wins
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h05; per_req[0] = 1'b1;
    @(negedge clk); reg_wr = 1'b0; per_req = '0;
    rd(2'd0, d); check("R4 hardware set wins over clear", d, 8'h07);
    wr(2'd0, 8'h05);
  endtask

  task automatic t_enables;
    int d;
    inst_bound = 1'b1;
    wr(2'd2, 8'h02);            // source 1 enabled, global off
    pulse(0);
    expect_quiet("R5 global off", 10);
    rd(2'd0, d); check("R5 flag still latched", d & 8'h02, 2);
    wr(2'd2, 8'h80);            // global on, source off
    expect_quiet("R5 source off", 10);
    wr(2'd2, 8'h82);
    expect_call("R5 enabled", vec_for(1));
    give_reti();
    wr(2'd2, 8'h00);
  endtask

  task automatic t_latency;
    int d, nb = 0, ve = 0;
    logic [15:0] v = '0;
    wr(2'd2, 8'h90);            // source 4
    inst_bound = 1'b1;
    @(negedge clk); per_req[2] = 1'b1;
    @(negedge clk); per_req = '0;   // flag visible now
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (call_busy) begin nb++; v = call_vec; end
      if (vec_enter && ve == 0) ve = k;
    end
    check("R6 busy length", nb, 6);
    check("R6 enter cycle", ve, 7);
    check("R6 vector 8n+3", int'(v), vec_for(4));
    rd(2'd0, d); check("R7 flag cleared on vectoring", d & 8'h20, 0);
    give_reti();
    wr(2'd2, 8'h00);
  endtask

  task automatic t_boundary;
    wr(2'd2, 8'h88);            // source 3
    inst_bound = 1'b0;
    pulse(1);
    expect_quiet("R13 no boundary", 8);
    inst_bound = 1'b1;
    expect_call("R13 boundary", vec_for(3));
    give_reti();
    wr(2'd2, 8'h00);
  endtask

  task automatic t_priority;
    inst_bound = 1'b0;
    wr(2'd3, 8'h10);            // source 4 high
    wr(2'd2, 8'h9A);            // sources 1,3,4
    wr(2'd0, 8'h2F);            // flags 1,3,4
    inst_bound = 1'b1;
    expect_call("R8 high level first", vec_for(4));
    give_reti();
    expect_call("R8 R10 lowest index in level", vec_for(1));
    give_reti();
    expect_call("R10 next pending", vec_for(3));
    give_reti();
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_nesting;
    int d;
    wr(2'd3, 8'h22);            // sources 1,5 high
    wr(2'd2, 8'hBA);            // sources 1,3,4,5
    inst_bound = 1'b1;
    pulse(1);
    expect_call("R9 low taken", vec_for(3));
    pulse(2);
    expect_quiet("R9 equal low waits", 10);
    rd(2'd0, d); check("R9 pending flag kept", d & 8'h20, 8'h20);
    pulse(0);
    expect_call("R9 high preempts low", vec_for(1));
    pulse(3);
    expect_quiet("R9 equal high waits", 10);
    give_reti();
    expect_call("R10 high released", vec_for(5));
    give_reti();
    expect_quiet("R10 low still in service", 10);
    give_reti();
    expect_call("R10 low released", vec_for(4));
    give_reti();
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_edge;
    int d;
    inst_bound = 1'b0;
    @(negedge clk); ext_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R11 falling edge sets", d, 1);
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R11 held low no re-set", d, 0);
    ext_n[0] = 1'b1;
    @(negedge clk); ext_n[1] = 1'b0;
    @(negedge clk); ext_n[1] = 1'b1;
    @(negedge clk);
    rd(2'd1, d); check("R11 pin 1 edge", d, 2);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_level;
    int d;
    wr(2'd0, 8'h04);            // pin 0 level mode
    @(negedge clk); ext_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd1, d); check("R12 low level sets", d, 1);
    wr(2'd1, 8'h00);
    @(negedge clk);
    rd(2'd1, d); check("R12 follows while low", d, 1);
    ext_n[0] = 1'b1;
    @(negedge clk);
    wr(2'd1, 8'h00);
    @(negedge clk);
    rd(2'd1, d); check("R12 clears after release", d, 0);
    wr(2'd0, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_layout();
    t_enables();
    t_latency();
    t_boundary();
    t_priority();
    t_nesting();
    t_edge();
    t_level();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule